// File: doc/BRIEF.md
# Ethernet Interrupt Status Controller

This block gathers the interrupt sources of a small Ethernet MAC into one interrupt line. Seven event inputs come from the receive path, the transmit path, the management interface and the PHY logic. A one-cycle pulse on any of them sets a matching bit in a sticky raw status register. Software reads this register at byte offset 0x00. It acknowledges events by writing ones to the same offset. Each written one clears the matching status bit. A mask register at offset 0x04 decides which status bits may drive the interrupt line. The mask comes out of reset with all seven sources enabled.

The interrupt output is a registered level. It is high while any status bit is both set and enabled in the mask.

Acknowledging the transmit-error bit has a side effect: the block sends a one-cycle reset strobe to the transmit framer. The framer then drops any partial frame and waits for a new length word.

The register port is a plain single-cycle write strobe with a combinational read-data path.

Top module: `eth_irq_ctrl`

## Requirements
- R1: After reset the status register is 0x00, the mask register is 0x7F, and `irq_o` and `txf_rst_o` are low.
- R2: A high level on `evt_i[b]` during a clock edge sets status bit b at that edge. The bit stays set until it is acknowledged. The bit meanings are: bit0 frame received, bit1 transmit error, bit2 transmit buffer empty, bit3 receive overrun, bit4 receive error, bit5 management transfer done, bit6 PHY event.
- R3: A read at offset 0x00 returns the status register in bits 6:0, with bits 31:7 equal to zero.
- R4: A write at offset 0x00 clears every status bit whose written data bit is one. Status bits whose written data bit is zero are left unchanged.
- R5: When an event and an acknowledge hit the same status bit at the same edge, the bit ends up set.
- R6: Offset 0x04 reads and writes the mask in bits 6:0. Written bits 31:7 are ignored, and those bits read back as zero.
- R7: `irq_o` equals the OR of (status AND mask) as it stood one clock earlier. It therefore rises or falls one cycle after a status or mask change.
- R8: A write at offset 0x00 with data bit 1 set drives `txf_rst_o` high for exactly the next cycle. A write to any other offset, or a write without bit 1 set, leaves `txf_rst_o` low.
- R9: A read at any offset other than 0x00 and 0x04 returns zero. A write to such an offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| evt_i | input | 7 | Event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt request, registered |
| txf_rst_o | output | 1 | One-cycle reset strobe to the transmit framer |

## Verification
The bench targets the set-versus-acknowledge race on one bit. A design that lets the clear win would silently lose an event.

It acknowledges a subset of bits to catch a clear that wipes the whole register. It writes all-ones data to the mask to expose upper bits leaking into read data.

It times `irq_o` exactly one cycle after each status and mask change. A combinational or two-stage output would miss that cycle.

It checks that the framer strobe fires only for an acknowledge carrying bit 1, and lasts one cycle. It also checks that a mask write carrying bit 1 raises no strobe.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int NUM_SRC   = 7;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int TXERR_BIT = 1;

  localparam logic [ADDR_W-1:0] OFFS_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] OFFS_MASK   = 8'h04;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/eth_irq_status.sv
module eth_irq_status #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] bit_en;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic clr_b;
    always_comb begin
      clr_b       = clr_en_i & clr_bits_i[b];
      // set dominates a simultaneous clear
      status_d[b] = set_i[b] | (status_q[b] & ~clr_b);
      bit_en[b]   = set_i[b] | clr_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[b] <= 1'b0;
      end else if (bit_en[b]) begin
        status_q[b] <= status_d[b];
      end
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/eth_irq_mask.sv
module eth_irq_mask #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  localparam logic [NUM_SRC-1:0] MASK_RST = {NUM_SRC{1'b1}};

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (wr_en_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/eth_irq_out.sv
module eth_irq_out #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               txerr_ack_i,
  output logic               irq_o,
  output logic               txf_rst_o
);
  logic irq_q, irq_d;
  logic strobe_q, strobe_d;

  always_comb begin
    irq_d    = |(status_i & mask_i);
    strobe_d = txerr_ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      irq_q    <= irq_d;
      strobe_q <= strobe_d;
    end
  end

  assign irq_o     = irq_q;
  assign txf_rst_o = strobe_q;
endmodule

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
  import eth_irq_pkg::*;
#(
  parameter int NUM_SRC   = eth_irq_pkg::NUM_SRC,
  parameter int DATA_W    = eth_irq_pkg::DATA_W,
  parameter int ADDR_W    = eth_irq_pkg::ADDR_W,
  parameter int TXERR_BIT = eth_irq_pkg::TXERR_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o,
  output logic               txf_rst_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic               ack_wr;
  logic               mask_wr;
  logic               txerr_ack;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;

  always_comb begin
    if (bus_addr == OFFS_STATUS)    sel = SEL_STATUS;
    else if (bus_addr == OFFS_MASK) sel = SEL_MASK;
    else                            sel = SEL_NONE;
  end

  always_comb begin
    ack_wr    = bus_wr && (sel == SEL_STATUS);
    mask_wr   = bus_wr && (sel == SEL_MASK);
    txerr_ack = ack_wr && bus_wdata[TXERR_BIT];
  end

  eth_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_i),
    .clr_en_i  (ack_wr),
    .clr_bits_i(bus_wdata[NUM_SRC-1:0]),
    .status_o  (status_q)
  );

  eth_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(mask_wr),
    .wdata_i(bus_wdata[NUM_SRC-1:0]),
    .mask_o (mask_q)
  );

  eth_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_i   (status_q),
    .mask_i     (mask_q),
    .txerr_ack_i(txerr_ack),
    .irq_o      (irq_o),
    .txf_rst_o  (txf_rst_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, status_q};
      SEL_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eth_irq_ctrl_chk.sv
module eth_irq_ctrl_chk
  import eth_irq_pkg::*;
#(
  parameter int NUM_SRC   = 7,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int TXERR_BIT = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               irq_o,
  input logic               txf_rst_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic               ack;
  logic [NUM_SRC-1:0] wbits;
  assign ack   = bus_wr && (bus_addr == OFFS_STATUS);
  assign wbits = bus_wdata[NUM_SRC-1:0];

  // R2: an event sets its bit at the edge
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R2: without an acknowledge no set bit falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4: acknowledged bits with no concurrent event are cleared
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((status_q & $past(wbits) & ~$past(evt_i)) == '0));

  // R5: a racing event survives the acknowledge
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && |(wbits & evt_i)) |=> ((status_q & $past(wbits & evt_i)) == $past(wbits & evt_i)));

  // R6: upper read bits are zero
  p_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);

  // R7: registered interrupt level
  p_irq_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(status_q) & $past(mask_q))));

  // R8: strobe follows a transmit-error acknowledge
  p_strobe_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && bus_wdata[TXERR_BIT]) |=> txf_rst_o);

  // R8: strobe only after such an acknowledge
  p_strobe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txf_rst_o |-> $past(ack && bus_wdata[TXERR_BIT]));
endmodule

bind eth_irq_ctrl eth_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TXERR_BIT(TXERR_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .evt_i    (evt_i),
  .irq_o    (irq_o),
  .txf_rst_o(txf_rst_o),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/sim_eth_irq_ctrl.sv
`timescale 1ns/1ps
module sim_eth_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_i = 7'h0;
  logic        irq_o;
  logic        txf_rst_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eth_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .irq_o(irq_o), .txf_rst_o(txf_rst_o)
  );

  // op: 0 event pulse, 1 write, 2 read-compare, 3 idle clock then irq compare
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {2'd2, 8'h00, 32'h0000_0000},  // R1 R3 status reset
    {2'd2, 8'h04, 32'h0000_007F},  // R1 R6 mask reset
    {2'd3, 8'h00, 32'h0000_0000},  // R7 idle
    {2'd0, 8'h00, 32'h0000_0001},  // rx event
    {2'd2, 8'h00, 32'h0000_0001},  // R2 R3
    {2'd3, 8'h00, 32'h0000_0001},  // R7 irq up
    {2'd1, 8'h04, 32'h0000_0000},  // mask off
    {2'd2, 8'h04, 32'h0000_0000},  // R6
    {2'd3, 8'h00, 32'h0000_0000},  // R7 masked
    {2'd0, 8'h00, 32'h0000_0048},  // overrun + phy
    {2'd2, 8'h00, 32'h0000_0049},  // R2 sticky
    {2'd1, 8'h00, 32'h0000_0008},  // ack overrun only
    {2'd2, 8'h00, 32'h0000_0041},  // R4 partial clear
    {2'd1, 8'h04, 32'hFFFF_FF40},  // mask phy, upper bits set
    {2'd2, 8'h04, 32'h0000_0040},  // R6 upper ignored
    {2'd3, 8'h00, 32'h0000_0001},  // R7
    {2'd1, 8'h00, 32'hFFFF_FFFF},  // ack all
    {2'd2, 8'h00, 32'h0000_0000},  // R4
    {2'd3, 8'h00, 32'h0000_0000},  // R7 irq down
    {2'd1, 8'h08, 32'hFFFF_FFFF},  // unmapped write
    {2'd2, 8'h08, 32'h0000_0000},  // R9 read zero
    {2'd2, 8'h00, 32'h0000_0000},  // R9 status untouched
    {2'd2, 8'h04, 32'h0000_0040},  // R9 mask untouched
    {2'd2, 8'h3C, 32'h0000_0000}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [6:0] e);
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_i = e;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; evt_i = '0; bus_wdata = '0;
    #0.5;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 strobe", {31'b0, txf_rst_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [7:0] a; logic [31:0] v;
      {op, a, v} = VEC[i];
      case (op)
        2'd0: cyc(1'b0, 8'h00, 32'h0, v[6:0]);
        2'd1: cyc(1'b1, a, v, 7'h0);
        2'd2: rd($sformatf("R3/R6/R9 vec%0d", i), a, v);
        default: begin
          cyc(1'b0, 8'h00, 32'h0, 7'h0);
          check($sformatf("R7 vec%0d", i), {31'b0, irq_o}, v);
        end
      endcase
    end

    // R5: event and acknowledge race on bit 2
    cyc(1'b0, 8'h00, 32'h0, 7'h04);
    cyc(1'b1, 8'h00, 32'h0000_0004, 7'h04);
    rd("R5 set wins", 8'h00, 32'h0000_0004);

    // R8: strobe after transmit-error acknowledge, exactly one cycle
    cyc(1'b1, 8'h00, 32'h0000_0002, 7'h0);
    check("R8 strobe high", {31'b0, txf_rst_o}, 32'h1);
    cyc(1'b0, 8'h00, 32'h0, 7'h0);
    check("R8 strobe one cycle", {31'b0, txf_rst_o}, 32'h0);
    cyc(1'b1, 8'h00, 32'h0000_0004, 7'h0);
    check("R8 no strobe other ack", {31'b0, txf_rst_o}, 32'h0);
    cyc(1'b1, 8'h04, 32'h0000_0002, 7'h0);
    check("R8 no strobe mask write", {31'b0, txf_rst_o}, 32'h0);

    // R1: reset mid-run restores defaults
    cyc(1'b0, 8'h00, 32'h0, 7'h7F);
    rst_n = 1'b0;
    #1;
    rd("R1 status after reset", 8'h00, 32'h0);
    rd("R1 mask after reset", 8'h04, 32'h7F);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule